// File: doc/BRIEF.md
# SD Host Internal Data Mover

This block moves a single contiguous buffer between system memory and the data path of an SD card host. Software sets the direction, the address behaviour and a 128-byte-aligned buffer address through a small register file, then writes a start bit. The host core supplies the number of words for the transfer on a length input. The block samples that length when the transfer starts.

For a write to the card, the engine reads words from memory over a request/acknowledge master port and presents them on a downstream valid/ready stream. For a read from the card, it takes words from an upstream valid/ready stream and writes them to memory. Each direction has its own reset bit, its own completion flag and its own error flag. Status flags are cleared by writing zero to them. A masked-OR of the flags drives one interrupt line.

Top module: `sd_dma_engine`

## Requirements
- R1: After reset, both mask registers (0x848, 0x858) read 0xFFFFFFFF. Both status registers (0x840, 0x850) read 0. The reset register (0x830) reads 0x300. The control register (0x828) reads 0. The interrupt is low.
- R2: When mode bit 16 is 0 (channel 0), a start on control bit 0 reads `len` words from memory (mem_we=0). The words appear on the downstream stream in order, and exactly `len` beats occur.
- R3: When mode bit 16 is 1 (channel 1), a start takes `len` words from the upstream stream in order and writes each one to memory (mem_we=1).
- R4: When mode bit 0 is 1, the memory address starts at the programmed address and advances by 4 bytes per word. When mode bit 0 is 0, every access uses the programmed address.
- R5: Completion sets status1 bit 16 for channel 0 and bit 20 for channel 1. The flag is set once the destination has accepted the last word. A length of 0 sets the flag at start, and no data moves.
- R6: A start with any of address bits 6:0 nonzero makes no memory request and moves no stream data. It sets status2 bit 16 for channel 0 or bit 17 for channel 1.
- R7: An acknowledge with mem_err high stops the transfer. It sets the channel's status2 error bit and leaves its completion bit clear.
- R8: Writing 0 to a status bit clears it. Writing 1 leaves it unchanged.
- R9: irq is high exactly when some status bit is set and its mask bit is 0.
- R10: Writing 0 to reset bit 8 (channel 0) or bit 9 (channel 1) aborts that channel's transfer: its stream and memory signals drop, and no completion flag is set. A start for a channel held in reset is ignored. Writing the bit back to 1 restores normal operation.
- R11: A start written while a transfer is active is ignored. The active transfer keeps its address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt, OR of unmasked status bits |
| xfer_len | input | 16 | Transfer length in words, sampled at start |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Error response, qualified by mem_ack |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| dn_valid | output | 1 | Downstream word valid |
| dn_ready | input | 1 | Downstream word accepted |
| dn_data | output | 32 | Downstream word |
| up_valid | input | 1 | Upstream word valid |
| up_ready | output | 1 | Upstream word accepted |
| up_data | input | 32 | Upstream word |

## Verification
The hardest state to reach is a transfer frozen partway through when a channel reset or a second start arrives. That moment must be stable, so the write to the reset or control register cannot race a data beat. The stimulus gets there by holding the card side of the stream idle, with downstream ready held low or upstream valid held low. This parks the engine in its card-side state before the register write lands. A short pause then shows at the ports that the signals have dropped, or that the first address is still in use. The full sweep covers both directions, both address modes, lengths 0 to 5, and fast and stalled handshakes. The expected addresses and data are computed arithmetically from the word index.

// File: rtl/sd_dma_pkg.sv
// Shared constants and types for the SD host data mover.
// Assumes a 32-bit register file and two channels (0 = to card, 1 = from card).
package sd_dma_pkg;
    localparam int NCH        = 2;
    localparam int OFS_MODE   = 'h820;
    localparam int OFS_CTRL   = 'h828;
    localparam int OFS_RST    = 'h830;
    localparam int OFS_STAT1  = 'h840;
    localparam int OFS_MASK1  = 'h848;
    localparam int OFS_STAT2  = 'h850;
    localparam int OFS_MASK2  = 'h858;
    localparam int OFS_ADDR   = 'h880;
    localparam int MODE_DIR   = 16;
    localparam int MODE_INC   = 0;
    localparam int MODE_WLO   = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_CARD = 2'd2
    } mv_state_t;

    // Completion flag position in status1 for a channel
    function automatic int done_pos(input int ch);
        return (ch == 0) ? 16 : 20;
    endfunction

    // Error flag position in status2 for a channel
    function automatic int fail_pos(input int ch);
        return 16 + ch;
    endfunction

    // Channel reset bit position in the reset register
    function automatic int hold_pos(input int ch);
        return 8 + ch;
    endfunction
endpackage

// File: rtl/sd_dma_addr_gen.sv
// Memory address generator: loads a base on start and steps by one word
// per completed memory access when increment mode is on.
// Assumes DATA_W is a multiple of 8.
module sd_dma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    localparam int BYTES = DATA_W / 8;

    // Address register: load, then advance in increment mode
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (step && inc)
            addr <= addr + ADDR_W'(BYTES);
    end
endmodule

// File: rtl/sd_dma_regs.sv
// Register file: mode, start, channel resets, status/mask pairs, buffer address.
// Status flags set on events from the mover and clear on a written 0.
// Assumes REG_AW is wide enough for the highest offset.
module sd_dma_regs #(
    parameter int REG_AW = 12,
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wen,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic                        mode_dir,
    output logic                        mode_inc,
    output logic [ADDR_W-1:0]           buf_addr,
    output logic                        start,
    output logic [sd_dma_pkg::NCH-1:0]  chan_rst_n,
    input  logic [sd_dma_pkg::NCH-1:0]  end_evt,
    input  logic [sd_dma_pkg::NCH-1:0]  err_evt,
    output logic                        irq
);
    import sd_dma_pkg::*;

    logic [1:0]     width_q;
    logic [31:0]    mask1_q, mask2_q;
    logic [NCH-1:0] done_q, fail_q, hold_q;

    wire wr_mode  = reg_wen && (reg_addr == REG_AW'(OFS_MODE));
    wire wr_rst   = reg_wen && (reg_addr == REG_AW'(OFS_RST));
    wire wr_stat1 = reg_wen && (reg_addr == REG_AW'(OFS_STAT1));
    wire wr_stat2 = reg_wen && (reg_addr == REG_AW'(OFS_STAT2));
    wire wr_mask1 = reg_wen && (reg_addr == REG_AW'(OFS_MASK1));
    wire wr_mask2 = reg_wen && (reg_addr == REG_AW'(OFS_MASK2));
    wire wr_addr  = reg_wen && (reg_addr == REG_AW'(OFS_ADDR));

    assign start      = reg_wen && (reg_addr == REG_AW'(OFS_CTRL)) && reg_wdata[0];
    assign chan_rst_n = hold_q;

    // Mode and buffer address configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_dir <= 1'b0;
            mode_inc <= 1'b0;
            width_q  <= 2'b00;
            buf_addr <= '0;
        end else begin
            if (wr_mode) begin
                mode_dir <= reg_wdata[MODE_DIR];
                mode_inc <= reg_wdata[MODE_INC];
                width_q  <= reg_wdata[MODE_WLO+1:MODE_WLO];
            end
            if (wr_addr)
                buf_addr <= reg_wdata[ADDR_W-1:0];
        end
    end

    // Interrupt masks, all sources blocked after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask1_q <= '1;
            mask2_q <= '1;
        end else begin
            if (wr_mask1) mask1_q <= reg_wdata;
            if (wr_mask2) mask2_q <= reg_wdata;
        end
    end

    logic [NCH-1:0] src_live;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            localparam int DP = done_pos(c);
            localparam int FP = fail_pos(c);
            localparam int HP = hold_pos(c);

            // Completion flag: event sets, written zero clears
            always_ff @(posedge clk) begin
                if (!rst_n)
                    done_q[c] <= 1'b0;
                else if (end_evt[c])
                    done_q[c] <= 1'b1;
                else if (wr_stat1 && !reg_wdata[DP])
                    done_q[c] <= 1'b0;
            end

            // Error flag: event sets, written zero clears
            always_ff @(posedge clk) begin
                if (!rst_n)
                    fail_q[c] <= 1'b0;
                else if (err_evt[c])
                    fail_q[c] <= 1'b1;
                else if (wr_stat2 && !reg_wdata[FP])
                    fail_q[c] <= 1'b0;
            end

            // Channel reset bit, released (1) after reset
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hold_q[c] <= 1'b1;
                else if (wr_rst)
                    hold_q[c] <= reg_wdata[HP];
            end

            assign src_live[c] = (done_q[c] && !mask1_q[DP]) || (fail_q[c] && !mask2_q[FP]);

            AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_stat1 && !reg_wdata[DP] && !end_evt[c]) |=> !done_q[c]); // R8
            AST_KEEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
                (done_q[c] && !(wr_stat1 && !reg_wdata[DP])) |=> done_q[c]); // R8
        end
    endgenerate

    assign irq = |src_live;

    // Read mux, combinational on the offset
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_AW'(OFS_MODE): begin
                reg_rdata[MODE_DIR]              = mode_dir;
                reg_rdata[MODE_INC]              = mode_inc;
                reg_rdata[MODE_WLO+1:MODE_WLO]   = width_q;
            end
            REG_AW'(OFS_RST): begin
                for (int c = 0; c < NCH; c++) reg_rdata[hold_pos(c)] = hold_q[c];
            end
            REG_AW'(OFS_STAT1): begin
                for (int c = 0; c < NCH; c++) reg_rdata[done_pos(c)] = done_q[c];
            end
            REG_AW'(OFS_STAT2): begin
                for (int c = 0; c < NCH; c++) reg_rdata[fail_pos(c)] = fail_q[c];
            end
            REG_AW'(OFS_MASK1): reg_rdata = mask1_q;
            REG_AW'(OFS_MASK2): reg_rdata = mask2_q;
            REG_AW'(OFS_ADDR):  reg_rdata[ADDR_W-1:0] = buf_addr;
            default:            reg_rdata = '0;
        endcase
    end

    AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask1_q && &mask2_q) |-> !irq); // R9
endmodule

// File: rtl/sd_dma_mover.sv
// Transfer engine: one channel at a time, alternating a memory access and a
// card-side stream beat per word. Checks alignment and channel reset at start.
// Assumes the memory port holds mem_ack for one cycle per request.
module sd_dma_mover #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 16,
    parameter int ALIGN_LG = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        dir_in,
    input  logic                        inc_in,
    input  logic [ADDR_W-1:0]           base_in,
    input  logic [LEN_W-1:0]            len_in,
    input  logic [sd_dma_pkg::NCH-1:0]  chan_rst_n,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic                        mem_ack,
    input  logic                        mem_err,
    input  logic [DATA_W-1:0]           mem_rdata,
    output logic                        dn_valid,
    input  logic                        dn_ready,
    output logic [DATA_W-1:0]           dn_data,
    input  logic                        up_valid,
    output logic                        up_ready,
    input  logic [DATA_W-1:0]           up_data,
    output logic [sd_dma_pkg::NCH-1:0]  end_evt,
    output logic [sd_dma_pkg::NCH-1:0]  err_evt
);
    import sd_dma_pkg::*;

    mv_state_t         state_q;
    logic              dir_q, inc_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q, cnt_q;
    logic [DATA_W-1:0] buf_q;

    wire misal     = |base_in[ALIGN_LG-1:0];
    wire active    = (state_q != ST_IDLE);
    wire live      = chan_rst_n[dir_q];
    wire accept    = start && !active && chan_rst_n[dir_in];
    wire abort     = active && !live;
    wire mem_ok    = (state_q == ST_MEM) && live && mem_ack && !mem_err;
    wire mem_bad   = (state_q == ST_MEM) && live && mem_ack && mem_err;
    wire card_beat = (state_q == ST_CARD) && live && (dir_q ? up_valid : dn_ready);
    wire last      = (cnt_q == len_q - LEN_W'(1));
    wire word_done = dir_q ? mem_ok : (card_beat && !dir_q);
    wire go        = accept && !misal && (len_in != '0);

    // Transfer sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= 1'b0;
            inc_q   <= 1'b0;
            base_q  <= '0;
            len_q   <= '0;
            buf_q   <= '0;
        end else if (abort) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (go) begin
                    state_q <= dir_in ? ST_CARD : ST_MEM;
                    dir_q   <= dir_in;
                    inc_q   <= inc_in;
                    base_q  <= base_in;
                    len_q   <= len_in;
                end
                ST_MEM: begin
                    if (mem_bad)
                        state_q <= ST_IDLE;
                    else if (mem_ok) begin
                        if (dir_q)
                            state_q <= last ? ST_IDLE : ST_CARD;
                        else begin
                            buf_q   <= mem_rdata;
                            state_q <= ST_CARD;
                        end
                    end
                end
                ST_CARD: if (card_beat) begin
                    if (dir_q) begin
                        buf_q   <= up_data;
                        state_q <= ST_MEM;
                    end else
                        state_q <= last ? ST_IDLE : ST_MEM;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Word counter, cleared at start, advanced on destination acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (go)
            cnt_q <= '0;
        else if (word_done && !abort)
            cnt_q <= cnt_q + LEN_W'(1);
    end

    sd_dma_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .base  (base_in),
        .step  (mem_ok),
        .inc   (inc_q),
        .addr  (mem_addr)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_evt
            assign end_evt[c] = (accept && (dir_in == 1'(c)) && !misal && (len_in == '0))
                              || (word_done && last && (dir_q == 1'(c)));
            assign err_evt[c] = (accept && (dir_in == 1'(c)) && misal)
                              || (mem_bad && (dir_q == 1'(c)));

            AST_END_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
                !(end_evt[c] && err_evt[c])); // R7
        end
    endgenerate

    assign mem_req   = (state_q == ST_MEM) && live;
    assign mem_we    = dir_q;
    assign mem_wdata = buf_q;
    assign dn_valid  = (state_q == ST_CARD) && !dir_q && live;
    assign dn_data   = buf_q;
    assign up_ready  = (state_q == ST_CARD) && dir_q && live;

    AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        !(dn_valid && up_ready)); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !start && live) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R4
    AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !inc_q) |-> (mem_addr == base_q)); // R4
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < len_q)); // R2
    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && misal) |=> (!mem_req && !dn_valid && !up_ready)); // R6
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE)); // R10
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && active && live) |=> $stable(base_q)); // R11
endmodule

// File: rtl/sd_dma_engine.sv
// Top of the SD host data mover: register file plus transfer engine.
// Assumes a single-cycle register write strobe and a combinational read.
module sd_dma_engine #(
    parameter int REG_AW   = 12,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int LEN_W    = 16,
    parameter int ALIGN_LG = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  logic [LEN_W-1:0]  xfer_len,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data
);
    import sd_dma_pkg::*;

    logic              mode_dir, mode_inc, start;
    logic [ADDR_W-1:0] buf_addr;
    logic [NCH-1:0]    chan_rst_n, end_evt, err_evt;

    sd_dma_regs #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wen    (reg_wen),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mode_dir   (mode_dir),
        .mode_inc   (mode_inc),
        .buf_addr   (buf_addr),
        .start      (start),
        .chan_rst_n (chan_rst_n),
        .end_evt    (end_evt),
        .err_evt    (err_evt),
        .irq        (irq)
    );

    sd_dma_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .ALIGN_LG(ALIGN_LG)) u_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dir_in     (mode_dir),
        .inc_in     (mode_inc),
        .base_in    (buf_addr),
        .len_in     (xfer_len),
        .chan_rst_n (chan_rst_n),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .mem_rdata  (mem_rdata),
        .dn_valid   (dn_valid),
        .dn_ready   (dn_ready),
        .dn_data    (dn_data),
        .up_valid   (up_valid),
        .up_ready   (up_ready),
        .up_data    (up_data),
        .end_evt    (end_evt),
        .err_evt    (err_evt)
    );
endmodule

// File: tb/sd_dma_engine_test.sv
module sd_dma_engine_test;
    logic        clk = 0, rst_n = 0;
    logic        reg_wen = 0;
    logic [11:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        irq;
    logic [15:0] xfer_len = 0;
    logic        mem_req, mem_we, mem_ack = 0, mem_err = 0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
    logic        dn_valid, dn_ready = 0, up_valid = 0, up_ready;
    logic [31:0] dn_data, up_data = 0;

    sd_dma_engine uut (.*);

    always #10 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    bit slow = 0, dn_hold = 0, up_hold = 0, fin = 0;
    int err_at = -1, ack_n = 0, rd_n = 0, wr_n = 0, dn_n = 0, up_idx = 0, req_cycles = 0;
    logic [31:0] rd_log[64], wr_log_a[64], wr_log_d[64], dn_log[64];

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h0001_0003) ^ 32'h3C3C_0F0F;
    endfunction
    function automatic logic [31:0] upw(input int i);
        return 32'hA500_0000 + 32'(i) * 32'h0101_0011;
    endfunction

    // Responders for the memory port and both card streams, driven at negedge
    initial forever begin
        @(negedge clk);
        cyc++;
        if (mem_req) req_cycles++;
        if (mem_req && (!slow || (cyc % 3 != 0))) begin
            mem_ack = 1;
            mem_err = (ack_n == err_at);
            ack_n++;
            if (mem_we) begin
                if (wr_n < 64) begin wr_log_a[wr_n] = mem_addr; wr_log_d[wr_n] = mem_wdata; end
                wr_n++;
            end else begin
                mem_rdata = pat(mem_addr);
                if (rd_n < 64) rd_log[rd_n] = mem_addr;
                rd_n++;
            end
        end else begin
            mem_ack = 0;
            mem_err = 0;
        end
        dn_ready = !dn_hold && (!slow || cyc[0]);
        if (dn_valid && dn_ready) begin
            if (dn_n < 64) dn_log[dn_n] = dn_data;
            dn_n++;
        end
        up_valid = !up_hold && (!slow || !cyc[0]);
        up_data  = upw(up_idx);
        if (up_valid && up_ready) up_idx++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        reg_wen = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_wen = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    task automatic clear_logs();
        #1;
        ack_n = 0; rd_n = 0; wr_n = 0; dn_n = 0; up_idx = 0; req_cycles = 0;
    endtask

    task automatic wait_flag(output logic [31:0] s1, output logic [31:0] s2);
        for (int k = 0; k < 400; k++) begin
            rd(12'h840, s1);
            rd(12'h850, s2);
            if ((s1 | s2) != 0) break;
        end
    endtask

    task automatic launch(input bit dir, input bit inc, input int len, input logic [31:0] base);
        wr(12'h820, (32'(dir) << 16) | 32'h30 | 32'(inc));
        wr(12'h880, base);
        xfer_len = 16'(len);
        wr(12'h828, 32'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, s1, s2, ea;
        int run;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(12'h848, v); chk("R1 mask1", v, 32'hFFFF_FFFF);
        rd(12'h858, v); chk("R1 mask2", v, 32'hFFFF_FFFF);
        rd(12'h840, v); chk("R1 stat1", v, 0);
        rd(12'h850, v); chk("R1 stat2", v, 0);
        rd(12'h830, v); chk("R1 rstreg", v, 32'h300);
        rd(12'h828, v); chk("R1 ctrl", v, 0);
        chk("R1 irq", 32'(irq), 0);

        wr(12'h848, ~((32'h1 << 16) | (32'h1 << 20)));
        // R2 R3 R4 R5 R9 R8 sweep
        run = 0;
        for (int dir = 0; dir < 2; dir++)
            for (int inc = 0; inc < 2; inc++)
                for (int len = 0; len < 6; len++) begin
                    logic [31:0] base;
                    base = 32'h0001_0000 + 32'(run) * 128;
                    slow = run[0];
                    clear_logs();
                    launch(dir[0], inc[0], len, base);
                    wait_flag(s1, s2);
                    chk(dir ? "R5 end ch1" : "R5 end ch0", s1, dir ? (32'h1 << 20) : (32'h1 << 16));
                    chk("R7 no err", s2, 0);
                    ok = 1;
                    for (int i = 0; i < len; i++) begin
                        ea = base + (inc ? 32'(4 * i) : 0);
                        if (dir == 0) begin
                            if (rd_log[i] !== ea || dn_log[i] !== pat(ea)) ok = 0;
                        end else begin
                            if (wr_log_a[i] !== ea || wr_log_d[i] !== upw(i)) ok = 0;
                        end
                    end
                    chk(dir ? "R3 R4 data" : "R2 R4 data", 32'(ok), 1);
                    chk(dir ? "R3 count" : "R2 count", dir ? 32'(wr_n) : 32'(dn_n), 32'(len));
                    chk("R9 irq on", 32'(irq), 1);
                    wr(12'h840, 32'hFFFF_FFFF);
                    rd(12'h840, v); chk("R8 write one keeps", v, s1);
                    wr(12'h840, 32'h0);
                    rd(12'h840, v); chk("R8 write zero clears", v, 0);
                    chk("R9 irq off", 32'(irq), 0);
                    run++;
                end
        slow = 0;

        // R6 misaligned start, both channels
        for (int dir = 0; dir < 2; dir++) begin
            clear_logs();
            launch(dir[0], 1'b1, 3, 32'h0002_0044);
            repeat (5) @(negedge clk);
            rd(12'h850, v); chk("R6 err bit", v, 32'h1 << (16 + dir));
            rd(12'h840, v); chk("R6 no end", v, 0);
            chk("R6 no request", 32'(req_cycles + dn_n + up_idx), 0);
            chk("R9 masked irq", 32'(irq), 0);
            wr(12'h858, ~(32'h1 << (16 + dir)));
            chk("R9 unmasked irq", 32'(irq), 1);
            wr(12'h850, 32'h0);
            wr(12'h858, 32'hFFFF_FFFF);
        end

        // R7 memory error response
        for (int dir = 0; dir < 2; dir++) begin
            clear_logs();
            err_at = 2;
            launch(dir[0], 1'b1, 4, 32'h0003_0000);
            wait_flag(s1, s2);
            repeat (4) @(negedge clk);
            rd(12'h850, s2); rd(12'h840, s1);
            chk("R7 err set", s2, 32'h1 << (16 + dir));
            chk("R7 end clear", s1, 0);
            chk("R7 acks stop", 32'(ack_n), 3);
            chk("R7 beats", dir ? 32'(up_idx) : 32'(dn_n), dir ? 3 : 2);
            err_at = -1;
            wr(12'h850, 32'h0);
        end

        // R10 channel reset aborts, start ignored while held
        clear_logs();
        dn_hold = 1;
        launch(1'b0, 1'b1, 3, 32'h0004_0000);
        repeat (6) @(negedge clk);
        chk("R10 ch0 parked", 32'(dn_valid), 1);
        wr(12'h830, 32'h200);
        repeat (3) @(negedge clk);
        chk("R10 ch0 valid dropped", 32'(dn_valid | mem_req), 0);
        clear_logs();
        wr(12'h828, 32'h1);
        repeat (8) @(negedge clk);
        chk("R10 start held ignored", 32'(req_cycles), 0);
        rd(12'h840, v); chk("R10 no end ch0", v, 0);
        wr(12'h830, 32'h300);
        dn_hold = 0;
        clear_logs();
        launch(1'b0, 1'b1, 2, 32'h0004_0080);
        wait_flag(s1, s2);
        chk("R10 ch0 after release", s1, 32'h1 << 16);
        chk("R10 ch0 beats", 32'(dn_n), 2);
        wr(12'h840, 32'h0);

        clear_logs();
        up_hold = 1;
        launch(1'b1, 1'b1, 2, 32'h0004_0100);
        repeat (6) @(negedge clk);
        chk("R10 ch1 parked", 32'(up_ready), 1);
        wr(12'h830, 32'h100);
        repeat (3) @(negedge clk);
        chk("R10 ch1 ready dropped", 32'(up_ready | mem_req), 0);
        rd(12'h840, v); chk("R10 no end ch1", v, 0);
        wr(12'h830, 32'h300);
        up_hold = 0;
        repeat (4) @(negedge clk);
        chk("R10 ch1 stays idle", 32'(up_ready), 0);

        // R11 start while busy is ignored
        clear_logs();
        dn_hold = 1;
        launch(1'b0, 1'b1, 3, 32'h0005_0000);
        repeat (4) @(negedge clk);
        wr(12'h880, 32'h0006_0000);
        xfer_len = 16'd5;
        wr(12'h828, 32'h1);
        dn_hold = 0;
        wait_flag(s1, s2);
        chk("R11 count kept", 32'(dn_n), 3);
        ok = 1;
        for (int i = 0; i < 3; i++)
            if (dn_log[i] !== pat(32'h0005_0000 + 32'(4 * i))) ok = 0;
        chk("R11 address kept", 32'(ok), 1);

        fin = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule